// File: doc/BRIEF.md
# Remote Interrupt and Mailbox Command Dispatcher

This block takes send commands issued by any core and turns each into one or two accesses on a shared request/response port that reaches the per-core register files. A command is a 64-bit word plus a 2-bit kind. The word names the target core and carries everything else the access needs. There are three kinds. A set-pending command raises one status bit in the target. A mailbox command writes one of eight 32-bit slots. An arbitrary-write command writes any 16-bit offset in the target's space.

Mailbox and arbitrary writes carry a 4-bit byte-keep mask. When the mask is zero, the payload is written directly. When any mask bit is set, the dispatcher first reads the target word. It then merges the kept old bytes with the payload bytes and writes the merged word back. The dispatcher holds off new commands until the whole sequence has finished. Each accepted command ends with a one-cycle completion pulse and a status code.

Top module: `ipi_send_dispatch`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `req_valid` and `done_valid` are 0.
- R2: Kind 0 (set-pending) sends exactly one request to core `cmd_data[25:16]` with `req_op` 2 (set bit), `req_addr` 0 and `req_wdata` equal to `1 << cmd_data[4:0]`. The keep mask is ignored for this kind.
- R3: Kind 1 (mailbox) targets address 0x20 + 4 × `cmd_data[4:2]`, and its payload is `cmd_data[63:32]`. Bits 1:0 of the command do not affect the address.
- R4: Kind 2 (arbitrary write) targets address `cmd_data[15:0]` with payload `cmd_data[63:32]`.
- R5: For kinds 1 and 2, when `cmd_data[30:27]` is zero, the dispatcher issues one write (`req_op` 1) and no read.
- R6: For kinds 1 and 2, when `cmd_data[30:27]` is nonzero, the dispatcher issues a read (`req_op` 0) and then a write. In the written word, byte i is the old byte if `cmd_data[27+i]` is 1, and the payload byte otherwise.
- R7: If the target core index is greater than or equal to the NUM_CORES parameter, no request is issued and `done_status` is 1.
- R8: Kind 3 is rejected with no request and `done_status` 3. This check takes priority over R7.
- R9: An error response to the read aborts the command with no write. An error response to the write also ends the command. In both cases `done_status` is 2.
- R10: Every accepted command produces exactly one one-cycle `done_valid` pulse. `done_status` is 0 on success, and `cmd_ready` returns to 1 in the cycle after the pulse.
- R11: `cmd_ready` stays 0 from the cycle after acceptance until the completion pulse has ended, so a read-merge-write is never interleaved with another command.
- R12: While `req_valid` is 1 and `req_ready` is 0, the request's op, core, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Dispatcher idle, command taken when valid |
| cmd_kind | input | 2 | 0 set-pending, 1 mailbox, 2 arbitrary write, 3 reserved |
| cmd_data | input | 64 | Command word |
| req_valid | output | 1 | Request to register files valid |
| req_ready | input | 1 | Register files accept the request |
| req_op | output | 2 | 0 read, 1 write, 2 set bit |
| req_core | output | 10 | Target core index |
| req_addr | output | 16 | Target register offset |
| req_wdata | output | 32 | Write data or bit mask |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_err | input | 1 | Response reports an error |
| rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Command finished (one cycle) |
| done_status | output | 2 | 0 ok, 1 no such core, 2 target error, 3 bad kind |

## Verification
The bench checks the byte-keep merge with several masks: none, all four bytes, a single high byte, and alternating bytes. A merge with the lanes swapped or the mask polarity inverted would leave the wrong bytes in the target. It sends core indices just past the last core and at the field's maximum. A range check off by one would then issue a request to a core that does not exist. It injects error responses on both the read and the write. A design that ignored a read error would go on to write a corrupted merge. The bench also stalls `req_ready` and sends a set-pending command with mask bits set. These catch a request that drifts while stalled, or a set command that wrongly starts a read.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;

  localparam int CMD_W    = 64;
  localparam int CORE_W   = 10;
  localparam int OFS_W    = 16;
  localparam int WORD_W   = 32;
  localparam int NBYTE    = WORD_W / 8;
  localparam int CORE_LSB = 16;
  localparam int KEEP_LSB = 27;
  localparam int PAY_LSB  = 32;
  localparam logic [OFS_W-1:0] MBOX_BASE = 16'h0020;

  typedef enum logic [1:0] {
    KIND_SET  = 2'd0,
    KIND_MBOX = 2'd1,
    KIND_ANY  = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SETBIT = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOCORE  = 2'd1,
    ST_TGTERR  = 2'd2,
    ST_BADKIND = 2'd3
  } status_e;

  typedef struct packed {
    logic [CORE_W-1:0] core;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] wdata;
    logic [NBYTE-1:0]  keep;
    logic              is_set;
    logic              bad_core;
    logic              bad_kind;
  } plan_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [1:0]       kind,
  output plan_t            plan
);

  logic [CORE_W-1:0] core_f;
  logic [NBYTE-1:0]  keep_f;
  logic [WORD_W-1:0] pay_f;
  logic              unused_bits;

  assign core_f      = cmd[CORE_LSB +: CORE_W];
  assign keep_f      = cmd[KEEP_LSB +: NBYTE];
  assign pay_f       = cmd[PAY_LSB +: WORD_W];
  assign unused_bits = ^{cmd[31], cmd[26]};

  always_comb begin
    plan          = '0;
    plan.core     = core_f;
    plan.bad_core = ({{(32-CORE_W){1'b0}}, core_f} >= 32'(NUM_CORES));
    case (kind_e'(kind))
      KIND_SET: begin
        plan.is_set = 1'b1;
        plan.ofs    = '0;
        plan.wdata  = WORD_W'(1) << cmd[4:0];
        plan.keep   = '0;
      end
      KIND_MBOX: begin
        plan.ofs   = MBOX_BASE + OFS_W'({cmd[4:2], 2'b00});
        plan.wdata = pay_f;
        plan.keep  = keep_f;
      end
      KIND_ANY: begin
        plan.ofs   = cmd[OFS_W-1:0];
        plan.wdata = pay_f;
        plan.keep  = keep_f;
      end
      default: begin
        plan.bad_kind = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
  parameter int NB = 4
) (
  input  logic [NB*8-1:0] old_w,
  input  logic [NB*8-1:0] new_w,
  input  logic [NB-1:0]   keep,
  output logic [NB*8-1:0] out_w
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign out_w[b*8 +: 8] = keep[b] ? old_w[b*8 +: 8] : new_w[b*8 +: 8];
  end

endmodule

// File: rtl/ipi_disp_seq.sv
module ipi_disp_seq
  import ipi_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  plan_t             plan,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [WORD_W-1:0] rsp_rdata,
  output logic              cmd_ready,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [CORE_W-1:0] req_core,
  output logic [OFS_W-1:0]  req_addr,
  output logic [WORD_W-1:0] old_word,
  output logic [WORD_W-1:0] payload,
  output logic [NBYTE-1:0]  keep,
  output logic              done_valid,
  output logic [1:0]        done_status
);

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_REQ  = 3'd1,
    SQ_RD_WAIT = 3'd2,
    SQ_WR_REQ  = 3'd3,
    SQ_WR_WAIT = 3'd4,
    SQ_DONE    = 3'd5
  } seq_e;

  seq_e              state_q, state_d;
  logic [CORE_W-1:0] core_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] pay_q;
  logic [WORD_W-1:0] old_q;
  logic [NBYTE-1:0]  keep_q;
  logic              set_q;
  status_e           stat_q, stat_d;
  logic              cap_en, old_en, stat_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    stat_d  = ST_OK;
    cap_en  = 1'b0;
    old_en  = 1'b0;
    stat_en = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          cap_en = 1'b1;
          if (plan.bad_kind) begin
            stat_en = 1'b1;
            stat_d  = ST_BADKIND;
            state_d = SQ_DONE;
          end else if (plan.bad_core) begin
            stat_en = 1'b1;
            stat_d  = ST_NOCORE;
            state_d = SQ_DONE;
          end else if (plan.keep != '0) begin
            state_d = SQ_RD_REQ;
          end else begin
            state_d = SQ_WR_REQ;
          end
        end
      end
      SQ_RD_REQ: begin
        if (req_ready) state_d = SQ_RD_WAIT;
      end
      SQ_RD_WAIT: begin
        if (rsp_valid) begin
          if (rsp_err) begin
            stat_en = 1'b1;
            stat_d  = ST_TGTERR;
            state_d = SQ_DONE;
          end else begin
            old_en  = 1'b1;
            state_d = SQ_WR_REQ;
          end
        end
      end
      SQ_WR_REQ: begin
        if (req_ready) state_d = SQ_WR_WAIT;
      end
      SQ_WR_WAIT: begin
        if (rsp_valid) begin
          stat_en = 1'b1;
          stat_d  = rsp_err ? ST_TGTERR : ST_OK;
          state_d = SQ_DONE;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      core_q  <= '0;
      ofs_q   <= '0;
      pay_q   <= '0;
      keep_q  <= '0;
      set_q   <= 1'b0;
      old_q   <= '0;
      stat_q  <= ST_OK;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        core_q <= plan.core;
        ofs_q  <= plan.ofs;
        pay_q  <= plan.wdata;
        keep_q <= plan.keep;
        set_q  <= plan.is_set;
      end
      if (old_en)  old_q  <= rsp_rdata;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign cmd_ready   = (state_q == SQ_IDLE);
  assign req_valid   = (state_q == SQ_RD_REQ) || (state_q == SQ_WR_REQ);
  assign req_op      = (state_q == SQ_RD_REQ) ? OP_READ : (set_q ? OP_SETBIT : OP_WRITE);
  assign req_core    = core_q;
  assign req_addr    = ofs_q;
  assign old_word    = old_q;
  assign payload     = pay_q;
  assign keep        = keep_q;
  assign done_valid  = (state_q == SQ_DONE);
  assign done_status = stat_q;

endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_kind,
  input  logic [63:0] cmd_data,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [1:0]  req_op,
  output logic [9:0]  req_core,
  output logic [15:0] req_addr,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [31:0] rsp_rdata,
  output logic        done_valid,
  output logic [1:0]  done_status
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  plan_t             plan;
  logic              accept;
  logic [WORD_W-1:0] old_word, payload;
  logic [NBYTE-1:0]  keep;

  assign accept = cmd_valid && cmd_ready;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) dec_i (
    .cmd  (cmd_data),
    .kind (cmd_kind),
    .plan (plan)
  );

  ipi_disp_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .accept      (accept),
    .plan        (plan),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .cmd_ready   (cmd_ready),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_core    (req_core),
    .req_addr    (req_addr),
    .old_word    (old_word),
    .payload     (payload),
    .keep        (keep),
    .done_valid  (done_valid),
    .done_status (done_status)
  );

  ipi_byte_merge #(.NB(NBYTE)) merge_i (
    .old_w (old_word),
    .new_w (payload),
    .keep  (keep),
    .out_w (req_wdata)
  );

endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
  parameter int NUM_CORES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_kind,
  input logic [9:0]  cmd_core,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic [9:0]  req_core,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        done_valid,
  input logic [1:0]  done_status
);

  assert_setbit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |-> ($countones(req_wdata) == 1));

  assert_read_then_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> !req_valid);

  assert_core_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({22'd0, req_core} < 32'(NUM_CORES)));

  assert_nocore_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind != 2'd3 && {22'd0, cmd_core} >= 32'(NUM_CORES))
      |=> (done_valid && done_status == 2'd1));

  assert_badkind_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd3) |=> (done_valid && done_status == 2'd3));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && cmd_ready));

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_core)
                                   && $stable(req_addr) && $stable(req_wdata)));

endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_kind    (cmd_kind),
  .cmd_core    (cmd_data[25:16]),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_core    (req_core),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .done_valid  (done_valid),
  .done_status (done_status)
);

// File: tb/ipi_send_dispatch_tb_top.sv
`timescale 1ns/1ps
module ipi_send_dispatch_tb_top;

  localparam int NCORE = 4;
  localparam logic [15:0] ERR_ADDR = 16'hBAD0;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_kind;
  logic [63:0] cmd_data;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [9:0]  req_core;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        done_valid;
  logic [1:0]  done_status;

  ipi_send_dispatch #(.NUM_CORES(NCORE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_core(req_core),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_status(done_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // behavioural register files of the targets
  int unsigned regs[int];
  int unsigned stat[int];
  int          req_cnt = 0;
  int          stall_left = 0;
  bit          rsp_pend = 1'b0;
  bit          pend_err;
  logic [31:0] pend_data;
  bit          was_stalled = 1'b0;
  logic [1:0]  h_op;
  logic [9:0]  h_core;
  logic [15:0] h_addr;
  logic [31:0] h_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned mread(int core, int addr);
    int k = core * 65536 + addr;
    return regs.exists(k) ? regs[k] : 0;
  endfunction

  function automatic int unsigned sread(int core);
    return stat.exists(core) ? stat[core] : 0;
  endfunction

  function automatic logic [63:0] mk(input logic [9:0] core, input logic [3:0] keepm,
                                     input logic [31:0] pay, input logic [15:0] low);
    return {pay, 1'b0, keepm, 1'b0, core, low};
  endfunction

  // responder: one cycle response after each accepted request
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b1; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
      rsp_pend = 1'b0; was_stalled = 1'b0;
    end else begin
      if (rsp_pend) begin
        rsp_valid = 1'b1; rsp_err = pend_err; rsp_rdata = pend_data; rsp_pend = 1'b0;
      end else begin
        rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
      end
      if (was_stalled)  // R12: held request while stalled
        chk(req_valid && req_op == h_op && req_core == h_core && req_addr == h_addr
            && req_wdata == h_wdata, "R12", "request held", {req_op, req_addr}, {h_op, h_addr});
      req_ready = (stall_left == 0);
      if (stall_left > 0) stall_left--;
      was_stalled = req_valid && !req_ready;
      h_op = req_op; h_core = req_core; h_addr = req_addr; h_wdata = req_wdata;
      if (req_valid && req_ready) begin
        req_cnt++;
        rsp_pend  = 1'b1;
        pend_err  = (req_addr == ERR_ADDR);
        pend_data = '0;
        if (!pend_err) begin
          case (req_op)
            2'd0: pend_data = mread(int'(req_core), int'(req_addr));
            2'd1: regs[int'(req_core) * 65536 + int'(req_addr)] = req_wdata;
            2'd2: stat[int'(req_core)] = sread(int'(req_core)) | req_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // issue one command, predict its effect, check completion and target state
  task automatic run(input string req, input logic [1:0] kind, input logic [63:0] d,
                     input int exp_st, input int exp_reqs);
    int core = int'(d[25:16]);
    int addr;
    int unsigned old, expw, exp_stat;
    int base, n;
    bit busy_ok = 1'b1;
    logic [31:0] pay = d[63:32];
    addr = (kind == 2'd1) ? (32'h20 + 4 * int'(d[4:2])) : int'(d[15:0]);
    old  = mread(core, addr);
    expw = old;
    for (int i = 0; i < 4; i++)
      if (exp_st == 0 && !d[27+i]) expw[i*8 +: 8] = pay[i*8 +: 8];
    exp_stat = sread(core) | (32'd1 << d[4:0]);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_data = d;
    base = req_cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done_valid && n < 100) begin
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (cmd_ready) busy_ok = 1'b0;
    chk(n < 100, req, "completion seen", n, 0);
    chk(busy_ok, "R11", "ready low while busy", busy_ok, 1);
    chk(done_status == 2'(exp_st), req, "status", done_status, exp_st);
    @(negedge clk);
    chk(cmd_ready && !done_valid, "R10", "single pulse then ready", {cmd_ready, done_valid}, 2'b10);
    chk(req_cnt - base == exp_reqs, req, "request count", req_cnt - base, exp_reqs);
    if (exp_st == 0 && kind == 2'd0)
      chk(sread(core) == exp_stat, req, "status word", sread(core), exp_stat);
    else if (kind == 2'd1 || kind == 2'd2)
      chk(mread(core, addr) == expw, req, "target word", mread(core, addr), expw);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = '0; cmd_data = '0;
    req_ready = 1'b1; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !req_valid && !done_valid, "R1", "reset outputs",
        {cmd_ready, req_valid, done_valid}, 3'b100);

    run("R2", 2'd0, mk(10'd1, 4'h0, 32'h0, 16'h0005), 0, 1);
    run("R2", 2'd0, mk(10'd1, 4'hF, 32'hFFFF_FFFF, 16'h001F), 0, 1);   // keep ignored
    run("R3_R5", 2'd1, mk(10'd2, 4'h0, 32'hA5A5_1234, 16'h000F), 0, 1); // slot 3, 0x2C
    run("R3_R6", 2'd1, mk(10'd2, 4'h5, 32'h1122_3344, 16'h000C), 0, 2); // expect 11A53334
    chk(mread(2, 16'h2C) == 32'h11A5_3334, "R6", "alternating merge", mread(2, 16'h2C), 32'h11A5_3334);
    run("R4_R5", 2'd2, mk(10'd3, 4'h0, 32'hDEAD_BEEF, 16'h1234), 0, 1);
    run("R4_R6", 2'd2, mk(10'd3, 4'hF, 32'h0000_0000, 16'h1234), 0, 2);
    run("R4_R6", 2'd2, mk(10'd3, 4'h8, 32'hCAFE_F00D, 16'h1234), 0, 2);
    chk(mread(3, 16'h1234) == 32'hDEFE_F00D, "R6", "high byte kept", mread(3, 16'h1234), 32'hDEFE_F00D);
    stall_left = 5;
    run("R12_R6", 2'd1, mk(10'd0, 4'h2, 32'h7788_99AA, 16'h001C), 0, 2);
    stall_left = 4;
    run("R12_R2", 2'd0, mk(10'd0, 4'h0, 32'h0, 16'h0000), 0, 1);
    run("R7", 2'd2, mk(10'd4, 4'h0, 32'h1, 16'h0040), 1, 0);
    run("R7", 2'd0, mk(10'd1023, 4'h0, 32'h1, 16'h0003), 1, 0);
    run("R8", 2'd3, mk(10'd9, 4'h0, 32'h1, 16'h0000), 3, 0);
    run("R9", 2'd2, mk(10'd0, 4'h1, 32'h5555_5555, ERR_ADDR), 2, 1);
    run("R9", 2'd2, mk(10'd0, 4'h0, 32'h6666_6666, ERR_ADDR), 2, 1);
    run("R10", 2'd1, mk(10'd3, 4'h0, 32'h0BAD_CAFE, 16'h0000), 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule